// File: doc/BRIEF.md
# I2C Slave Write-Frame Receiver

This block listens to an I2C bus as a slave that only accepts write transfers of any length. A fast system clock oversamples the open-drain SCL and SDA lines after a two-flop synchronizer. From the synchronized levels it finds START, repeated START and STOP conditions and shifts in bits on rising SCL. It then checks the 7-bit address and direction bit, pulls SDA low for the acknowledge slot, and stores each complete data byte in a small local buffer.

The end of a frame is known only from the STOP condition, because the payload has no fixed length. On STOP, if the frame was addressed to this device, the block raises a one-cycle completion flag and holds the number of complete bytes received. The buffer write position returns to zero when the address matches, not when STOP arrives. The contents therefore stay readable through the read port after the frame has ended, until the next matching address.

Top module: `i2cRxFramer`

## Requirements
- R1: After reset, `sdaPullLow` and `frameDone` are 0.
- R2: A fall of SDA while SCL is high is a START, and a rise of SDA while SCL is high is a STOP. A STOP that ends an addressed frame makes `frameDone` go high.
- R3: The first byte after a START is the 7-bit address, most significant bit first, followed by a direction bit. When the address equals `DEV_ADDR` and the direction bit is 0 (write), the block drives SDA low (`sdaPullLow`=1) for the ninth clock. That drive starts only while SCL is low.
- R4: A different address, or the direction bit at 1, gets no acknowledge (SDA stays 1 in the ninth clock). The bytes that follow are neither acknowledged nor stored, and the following STOP produces no `frameDone`.
- R5: Data bytes are taken most significant bit first and acknowledged. They are stored at buffer positions 0, 1, 2, … in arrival order and can be read combinationally at `rdData` for address `rdAddr`.
- R6: At STOP, `frameCount` equals the number of complete data bytes stored since the address match. This includes 0 for an address-only frame. The value holds until the next completed frame.
- R7: A data byte cut short by a STOP is not counted and not stored.
- R8: A repeated START discards any partial byte and re-enters the address phase. A new address match clears the write position, so the count covers only bytes after the last match.
- R9: With `BUF_DEPTH` bytes stored, further data bytes get a NAK (SDA 1 in the ninth clock) and are discarded. `frameCount` stops at `BUF_DEPTH` and the stored bytes are unchanged.
- R10: `frameDone` is high for exactly one clock cycle per completed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaPullLow | output | 1 | Enable for the open-drain SDA pull-down |
| rdAddr | input | $clog2(BUF_DEPTH) | Buffer read position |
| rdData | output | 8 | Byte stored at `rdAddr` |
| frameDone | output | 1 | One-cycle pulse when an addressed frame ends with STOP |
| frameCount | output | $clog2(BUF_DEPTH+1) | Complete data bytes in the last finished frame |

## Verification
A change on `sdaIn` reaches the event detectors on the second rising edge, and `frameDone` rises on the third. The pull-down enable turns on at the third edge after the SCL fall that closes the eighth bit. The bench therefore samples the acknowledge level halfway through the high phase of the ninth SCL pulse, which is well after the drive has settled. A monitor process waits for the `frameDone` pulse instead of counting a fixed delay. It compares the count at that negative edge and then checks that the flag is low one cycle later. After that it reads the buffer while the driver keeps the bus idle long enough for the reads to finish.

// File: rtl/i2cRxPkg.sv
package i2cRxPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_NACK,
    ST_SKIP
  } rxStateT;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
  } busEvtT;

  typedef struct packed {
    logic shiftEn;
    logic clrBits;
    logic clrIdx;
    logic wrEn;
  } dpStrobeT;

endpackage

// File: rtl/i2cRxSync.sv
module i2cRxSync
  import i2cRxPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclIn,
  input  logic   sdaIn,
  output logic   sclS,
  output logic   sdaS,
  output busEvtT evt
);

  logic [SYNC_STAGES-1:0] sclQ, sdaQ;
  logic sclP, sdaP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= '1;
      sdaQ <= '1;
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclQ <= {sclQ[SYNC_STAGES-2:0], sclIn};
      sdaQ <= {sdaQ[SYNC_STAGES-2:0], sdaIn};
      sclP <= sclQ[SYNC_STAGES-1];
      sdaP <= sdaQ[SYNC_STAGES-1];
    end
  end

  assign sclS = sclQ[SYNC_STAGES-1];
  assign sdaS = sdaQ[SYNC_STAGES-1];

  always_comb begin
    evt.sclRise   = sclS & ~sclP;
    evt.sclFall   = ~sclS & sclP;
    evt.startSeen = sclS & sclP & sdaP & ~sdaS;
    evt.stopSeen  = sclS & sclP & ~sdaP & sdaS;
  end

endmodule

// File: rtl/i2cRxData.sv
module i2cRxData
  import i2cRxPkg::*;
#(
  parameter int BUF_DEPTH = 8,
  localparam int IDX_W = $clog2(BUF_DEPTH),
  localparam int CNT_W = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobeT         strobe,
  input  logic             sdaBit,
  input  logic [IDX_W-1:0] rdAddr,
  output logic [7:0]       rxByte,
  output logic             byteFull,
  output logic             bufFull,
  output logic [CNT_W-1:0] count,
  output logic [7:0]       rdData
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(BUF_DEPTH);

  logic [3:0] bitCnt;
  logic [7:0] bufMem [BUF_DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxByte <= '0;
    end else if (strobe.clrBits) begin
      bitCnt <= '0;
    end else if (strobe.shiftEn) begin
      rxByte <= {rxByte[6:0], sdaBit};
      bitCnt <= bitCnt + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.clrIdx) begin
      count <= '0;
    end else if (strobe.wrEn) begin
      count <= count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) bufMem[count[IDX_W-1:0]] <= rxByte;
  end

  assign byteFull = (bitCnt == 4'd8);
  assign bufFull  = (count == DEPTH_C);
  assign rdData   = bufMem[rdAddr];

  assert_write_in_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (count < DEPTH_C));

  assert_clear_on_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrIdx |=> (count == '0));

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    count <= DEPTH_C);

endmodule

// File: rtl/i2cRxCtrl.sv
module i2cRxCtrl
  import i2cRxPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  busEvtT           evt,
  input  logic             sclS,
  input  logic [7:0]       rxByte,
  input  logic             byteFull,
  input  logic             bufFull,
  input  logic [CNT_W-1:0] count,
  output dpStrobeT         strobe,
  output logic             ackDrive,
  output logic             frameDone,
  output logic [CNT_W-1:0] frameCount
);

  rxStateT state, nextState;
  logic matched, nextMatched, doneNow;

  always_comb begin
    strobe      = '0;
    nextState   = state;
    nextMatched = matched;
    doneNow     = 1'b0;
    if (evt.stopSeen) begin
      nextState   = ST_IDLE;
      doneNow     = matched;
      nextMatched = 1'b0;
    end else if (evt.startSeen) begin
      nextState      = ST_ADDR;
      strobe.clrBits = 1'b1;
      nextMatched    = 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_DATA: begin
          if (evt.sclRise && !byteFull) strobe.shiftEn = 1'b1;
          if (evt.sclFall && byteFull) begin
            if (state == ST_ADDR) begin
              if (rxByte[7:1] == DEV_ADDR && !rxByte[0]) begin
                nextState     = ST_ACK;
                strobe.clrIdx = 1'b1;
                nextMatched   = 1'b1;
              end else begin
                nextState = ST_SKIP;
              end
            end else if (!bufFull) begin
              strobe.wrEn = 1'b1;
              nextState   = ST_ACK;
            end else begin
              nextState = ST_NACK;
            end
          end
        end
        ST_ACK, ST_NACK: begin
          if (evt.sclFall) begin
            nextState      = ST_DATA;
            strobe.clrBits = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      matched    <= 1'b0;
      frameDone  <= 1'b0;
      frameCount <= '0;
    end else begin
      state     <= nextState;
      matched   <= nextMatched;
      frameDone <= doneNow;
      if (doneNow) frameCount <= count;
    end
  end

  assign ackDrive = (state == ST_ACK);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  assert_ack_rise_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrive) |-> !sclS);

  assert_no_ack_unmatched_R4: assert property (@(posedge clk) disable iff (!rstN)
    ackDrive |-> matched);

endmodule

// File: rtl/i2cRxFramer.sv
module i2cRxFramer
  import i2cRxPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter int BUF_DEPTH = 8,
  localparam int IDX_W = $clog2(BUF_DEPTH),
  localparam int CNT_W = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaPullLow,
  input  logic [IDX_W-1:0] rdAddr,
  output logic [7:0]       rdData,
  output logic             frameDone,
  output logic [CNT_W-1:0] frameCount
);

  busEvtT     evt;
  dpStrobeT   strobe;
  logic       sclS, sdaS;
  logic [7:0] rxByte;
  logic       byteFull, bufFull;
  logic [CNT_W-1:0] count;

  i2cRxSync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .evt(evt)
  );

  i2cRxCtrl #(.DEV_ADDR(DEV_ADDR), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .sclS(sclS), .rxByte(rxByte),
    .byteFull(byteFull), .bufFull(bufFull), .count(count),
    .strobe(strobe), .ackDrive(sdaPullLow), .frameDone(frameDone),
    .frameCount(frameCount)
  );

  i2cRxData #(.BUF_DEPTH(BUF_DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaS), .rdAddr(rdAddr),
    .rxByte(rxByte), .byteFull(byteFull), .bufFull(bufFull), .count(count),
    .rdData(rdData)
  );

endmodule

// File: tb/i2cRxFramer_tb.sv
module i2cRxFramer_tb;

  localparam logic [6:0] ADDR = 7'h2C;
  localparam int DEPTH = 8;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaLine;
  logic sdaPullLow, frameDone;
  logic [IDX_W-1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [CNT_W-1:0] frameCount;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int expCount[$];
  logic [7:0] expData[$];

  always #5 clk = ~clk;

  assign sdaLine = sdaM & ~sdaPullLow;

  i2cRxFramer #(.DEV_ADDR(ADDR), .BUF_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .rdAddr(rdAddr), .rdData(rdData),
    .frameDone(frameDone), .frameCount(frameCount)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitCyc(Q);
    sclM = 1'b1; waitCyc(Q);
    sdaM = 1'b0; waitCyc(Q);
    sclM = 1'b0; waitCyc(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitCyc(Q);
    sclM = 1'b1; waitCyc(Q);
    sdaM = 1'b1; waitCyc(4 * Q);
  endtask

  task automatic sendBit(logic b);
    sdaM = b;    waitCyc(Q);
    sclM = 1'b1; waitCyc(Q);
    sclM = 1'b0; waitCyc(Q);
  endtask

  // eight bits MSB first, then the ninth clock where the level is checked
  task automatic sendByte(logic [7:0] b, bit expAck, bit keep, string req);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; waitCyc(Q);
    sclM = 1'b1; waitCyc(Q / 2);
    check(sdaLine == !expAck, req, "ack slot SDA level", sdaLine, !expAck);
    waitCyc(Q - Q / 2);
    sclM = 1'b0; waitCyc(Q);
    if (keep) expData.push_back(b);
  endtask

  task automatic sendAddr(logic [6:0] a, logic rd, bit expAck, string req);
    sendByte({a, rd}, expAck, 1'b0, req);
  endtask

  // monitor: scoreboard pops the expected frame when the pulse shows up
  initial begin
    forever begin
      @(negedge clk);
      if (frameDone) begin
        if (expCount.size() == 0) begin
          check(1'b0, "R4", "unexpected frameDone", 1, 0);
        end else begin
          int n;
          n = expCount.pop_front();
          check(frameCount == CNT_W'(n), "R6", "frameCount", frameCount, n);
          @(negedge clk);
          check(!frameDone, "R10", "frameDone second cycle", frameDone, 0);
          for (int i = 0; i < n; i++) begin
            logic [7:0] e;
            rdAddr = i[IDX_W-1:0];
            @(negedge clk);
            e = expData.pop_front();
            check(rdData == e, "R5", "buffer byte", rdData, e);
          end
        end
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        check(1'b0, "R2", "watchdog expired", cyc, 150000);
        summary();
      end
    end
  end

  initial begin
    waitCyc(5);
    check(sdaPullLow == 1'b0, "R1", "sdaPullLow after reset", sdaPullLow, 0);
    check(frameDone == 1'b0, "R1", "frameDone after reset", frameDone, 0);
    rstN = 1'b1;
    waitCyc(5);

    // R2 R3 R5: plain write of three bytes
    busStart();
    sendAddr(ADDR, 1'b0, 1'b1, "R3");
    sendByte(8'hA5, 1'b1, 1'b1, "R5");
    sendByte(8'h3C, 1'b1, 1'b1, "R5");
    sendByte(8'hF0, 1'b1, 1'b1, "R5");
    expCount.push_back(3);
    busStop();

    // R6: address-only frame
    busStart();
    sendAddr(ADDR, 1'b0, 1'b1, "R3");
    expCount.push_back(0);
    busStop();

    // R4: other address, then read direction
    busStart();
    sendAddr(ADDR ^ 7'h01, 1'b0, 1'b0, "R4");
    sendByte(8'h55, 1'b0, 1'b0, "R4");
    busStop();
    busStart();
    sendAddr(ADDR, 1'b1, 1'b0, "R4");
    sendByte(8'h66, 1'b0, 1'b0, "R4");
    busStop();
    check(expCount.size() == 0, "R4", "no frame pending", expCount.size(), 0);

    // R7: stop in the middle of a byte
    busStart();
    sendAddr(ADDR, 1'b0, 1'b1, "R3");
    sendByte(8'h81, 1'b1, 1'b1, "R5");
    sendByte(8'h7E, 1'b1, 1'b1, "R5");
    for (int i = 0; i < 5; i++) sendBit(i[0]);
    expCount.push_back(2);
    busStop();

    // R8: repeated start after a partial byte
    busStart();
    sendAddr(ADDR, 1'b0, 1'b1, "R8");
    sendByte(8'h11, 1'b1, 1'b0, "R8");
    for (int i = 0; i < 3; i++) sendBit(1'b0);
    busStart();
    sendAddr(ADDR, 1'b0, 1'b1, "R8");
    sendByte(8'hC3, 1'b1, 1'b1, "R8");
    sendByte(8'h00, 1'b1, 1'b1, "R8");
    expCount.push_back(2);
    busStop();

    // R9: overfill the buffer
    busStart();
    sendAddr(ADDR, 1'b0, 1'b1, "R3");
    for (int i = 0; i < DEPTH; i++) sendByte(8'(8'h20 + i * 7), 1'b1, 1'b1, "R9");
    sendByte(8'hEE, 1'b0, 1'b0, "R9");
    sendByte(8'hDD, 1'b0, 1'b0, "R9");
    expCount.push_back(DEPTH);
    busStop();

    // R6: single byte frame
    busStart();
    sendAddr(ADDR, 1'b0, 1'b1, "R3");
    sendByte(8'hFF, 1'b1, 1'b1, "R5");
    expCount.push_back(1);
    busStop();

    waitCyc(20);
    check(expCount.size() == 0, "R2", "frames still expected", expCount.size(), 0);
    check(expData.size() == 0, "R5", "bytes still expected", expData.size(), 0);
    finished = 1'b1;
    summary();
  end

endmodule